// File: doc/BRIEF.md
# Binary Matrix-Vector Argmax Engine

The block holds a bit-matrix of `NCOLS` columns, each `VEC_BITS` bits tall, and scores a streamed bit-vector against every column. A column's score is the number of bit positions where both the vector and the column hold a one: a bitwise AND followed by a population count. Once a whole vector has arrived, the block reports the highest score and the index of the column that reached it. One result is produced for each vector.

The vector arrives as `NCHUNK = VEC_BITS / CHUNK_W` chunks over a valid/ready handshake. Each accepted chunk is ANDed with the matching slice of every column, and the per-column population counts are added into a bank of accumulators. The accumulators also act as the buffer for the reduction. A single comparator then walks the columns one per cycle, so the reduction costs one comparator and `NCOLS` cycles per vector. The matrix is loaded slice by slice through a write port addressed by column and chunk number. That port only takes writes while no vector is in flight.

Top module: `bmv_argmax_top`

## Requirements
- R1: The score of column c is the popcount of (vector AND column c). `res_max` equals the largest score over all columns, and `res_idx` names a column that has that score.
- R2: A chunk transfers on a rising clock edge where `in_valid` and `in_ready` are both high. Chunk k carries vector bits `[k*CHUNK_W +: CHUNK_W]`. It is matched against slice k of each column. A vector is always exactly `NCHUNK` chunks.
- R3: `res_max` lies in 0..`VEC_BITS`. An all-one vector against an all-one column gives `VEC_BITS`. An all-zero vector gives 0 with index 0.
- R4: When several columns share the largest score, `res_idx` is the lowest such column index.
- R5: `in_ready` is high after reset. It goes low from the edge that accepts a vector's final chunk and stays low through the result cycle. It is high again one cycle after `res_valid`.
- R6: `res_valid` is a one-cycle pulse. It is first seen exactly `NCOLS` rising edges after the edge that accepted the final chunk, once per vector. `res_max`, `res_idx` and `res_frame_err` are valid in that cycle.
- R7: The accumulators restart at each vector's first chunk, so no count from an earlier vector enters a later result.
- R8: A write with `ld_en` high stores `ld_data` into slice `ld_chunk` of column `ld_col`. The write is ignored while a vector is partly received, during the reduction and in the result cycle. It is also ignored when `ld_chunk >= NCHUNK`.
- R9: `res_frame_err` is high with a result exactly when, for some chunk of that vector, `in_last` differed from "this is chunk `NCHUNK-1`". The vector length stays `NCHUNK` chunks either way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Matrix slice write strobe |
| ld_col | input | IDX_W | Column number of the write |
| ld_chunk | input | CHK_W | Slice (chunk) number of the write |
| ld_data | input | CHUNK_W | Slice contents |
| in_valid | input | 1 | Vector chunk present |
| in_ready | output | 1 | Block accepts a chunk |
| in_data | input | CHUNK_W | Vector chunk bits |
| in_last | input | 1 | Sender marks the final chunk |
| res_valid | output | 1 | Result pulse |
| res_max | output | CNT_W | Largest column score |
| res_idx | output | IDX_W | Column reaching the largest score |
| res_frame_err | output | 1 | `in_last` disagreed with chunk position |

## Verification
The bench counts the rising edges from the one that accepts the final chunk until `res_valid` is seen, and requires exactly `NCOLS`. It samples on falling edges so the edge count is unambiguous. In each of those cycles it also requires `in_ready` to be low. One edge after the pulse it requires `in_ready` high and `res_valid` low. Matrix writes that should be ignored are issued between chunks, during the scan and with an out-of-range slice number. Each is aimed so that, if it landed, it would change a later result, and that later result is compared with a software model built from the same column contents.

// File: rtl/bmv_pkg.sv
package bmv_pkg;
  // Control phases of the engine
  typedef enum logic [1:0] {
    PH_RECV = 2'd0,  // taking chunks (or idle)
    PH_SCAN = 2'd1,  // comparator walking the columns
    PH_EMIT = 2'd2   // result cycle
  } phase_e;
endpackage

// File: rtl/bmv_colmem.sv
module bmv_colmem #(
  parameter int NCOLS   = 16,
  parameter int NCHUNK  = 10,
  parameter int CHUNK_W = 100,
  localparam int IDX_W  = $clog2(NCOLS),
  localparam int CHK_W  = $clog2(NCHUNK),
  localparam int ADDR_W = $clog2(NCOLS * NCHUNK)
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_col,
  input  logic [CHK_W-1:0]         wr_chunk,
  input  logic [CHUNK_W-1:0]       wr_data,
  input  logic [CHK_W-1:0]         rd_chunk,
  output logic [NCOLS*CHUNK_W-1:0] rd_slices
);
  logic [CHUNK_W-1:0] mem_q [NCOLS*NCHUNK];

  function automatic logic [ADDR_W-1:0] slot(input logic [IDX_W-1:0] col,
                                            input logic [CHK_W-1:0] chk);
    return ADDR_W'(col) * ADDR_W'(NCHUNK) + ADDR_W'(chk);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[slot(wr_col, wr_chunk)] <= wr_data;
  end

  // Every column's slice for the current chunk, side by side
  for (genvar c = 0; c < NCOLS; c++) begin : g_rd
    assign rd_slices[c*CHUNK_W +: CHUNK_W] = mem_q[slot(IDX_W'(c), rd_chunk)];
  end
endmodule

// File: rtl/bmv_accum.sv
module bmv_accum #(
  parameter int NCOLS   = 16,
  parameter int CHUNK_W = 100,
  parameter int MAX_CNT = 1000,
  localparam int CNT_W  = $clog2(MAX_CNT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fire,
  input  logic                     first,
  input  logic [CHUNK_W-1:0]       chunk,
  input  logic [NCOLS*CHUNK_W-1:0] slices,
  output logic [NCOLS*CNT_W-1:0]   acc_flat
);
  // Population count of the AND of two chunk-wide words
  function automatic logic [CNT_W-1:0] and_pop(input logic [CHUNK_W-1:0] a,
                                               input logic [CHUNK_W-1:0] b);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < CHUNK_W; i++) s = s + CNT_W'(a[i] & b[i]);
    return s;
  endfunction

  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] part;
    assign part = and_pop(chunk, slices[c*CHUNK_W +: CHUNK_W]);

    always_ff @(posedge clk) begin
      if (!rst_n)            acc_q <= '0;
      else if (fire && first) acc_q <= part;          // R7 restart
      else if (fire)          acc_q <= acc_q + part;
      if (rst_n) begin
        p_acc_bound_r3: assert (acc_q <= CNT_W'(MAX_CNT));
      end
    end
    assign acc_flat[c*CNT_W +: CNT_W] = acc_q;
  end
endmodule

// File: rtl/bmv_scan.sv
module bmv_scan #(
  parameter int NCOLS  = 16,
  parameter int CNT_W  = 10,
  localparam int IDX_W = $clog2(NCOLS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NCOLS*CNT_W-1:0] acc_flat,
  output logic                   busy,
  output logic                   done,
  output logic [CNT_W-1:0]       best_val,
  output logic [IDX_W-1:0]       best_idx
);
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cur;
  logic             take;

  assign cur  = acc_flat[idx_q*CNT_W +: CNT_W];
  // strict compare keeps the earliest column on equal scores (R4)
  assign take = (idx_q == '0) || (cur > best_val);
  assign done = busy && (idx_q == IDX_W'(NCOLS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx_q    <= '0;
      best_val <= '0;
      best_idx <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      idx_q    <= '0;
      best_val <= '0;
      best_idx <= '0;
    end else if (busy) begin
      if (take) begin
        best_val <= cur;
        best_idx <= idx_q;
      end
      if (done) busy <= 1'b0;
      else      idx_q <= idx_q + 1'b1;
    end
  end

  p_best_rising_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (best_val >= $past(best_val)));

  p_tie_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (best_idx != $past(best_idx)))
      |-> (best_val > $past(best_val)));
endmodule

// File: rtl/bmv_argmax_top.sv
module bmv_argmax_top
  import bmv_pkg::*;
#(
  parameter int VEC_BITS = 1000,
  parameter int CHUNK_W  = 100,
  parameter int NCOLS    = 16,
  localparam int NCHUNK  = VEC_BITS / CHUNK_W,
  localparam int CNT_W   = $clog2(VEC_BITS + 1),
  localparam int IDX_W   = $clog2(NCOLS),
  localparam int CHK_W   = $clog2(NCHUNK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [IDX_W-1:0]   ld_col,
  input  logic [CHK_W-1:0]   ld_chunk,
  input  logic [CHUNK_W-1:0] ld_data,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CHUNK_W-1:0] in_data,
  input  logic               in_last,
  output logic               res_valid,
  output logic [CNT_W-1:0]   res_max,
  output logic [IDX_W-1:0]   res_idx,
  output logic               res_frame_err
);
  phase_e           phase_q;
  logic [CHK_W-1:0] chunk_q;
  logic             err_q;

  // Named events
  logic fire, first_chunk, final_chunk, vec_done, ld_ok, last_bad;
  logic scan_busy, scan_done;
  logic [NCOLS*CHUNK_W-1:0] slices;
  logic [NCOLS*CNT_W-1:0]   acc_flat;

  assign in_ready    = (phase_q == PH_RECV);
  assign fire        = in_valid && in_ready;
  assign first_chunk = (chunk_q == '0);
  assign final_chunk = (chunk_q == CHK_W'(NCHUNK - 1));
  assign vec_done    = fire && final_chunk;
  assign last_bad    = in_last != final_chunk;
  assign ld_ok       = ld_en && (phase_q == PH_RECV) && first_chunk
                       && ({1'b0, ld_chunk} < (CHK_W+1)'(NCHUNK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_RECV;
      chunk_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (fire) begin
        chunk_q <= final_chunk ? '0 : chunk_q + 1'b1;
        err_q   <= first_chunk ? last_bad : (err_q | last_bad);
      end
      case (phase_q)
        PH_RECV: if (vec_done)  phase_q <= PH_SCAN;
        PH_SCAN: if (scan_done) phase_q <= PH_EMIT;
        default:                phase_q <= PH_RECV;
      endcase
    end
  end

  bmv_colmem #(.NCOLS(NCOLS), .NCHUNK(NCHUNK), .CHUNK_W(CHUNK_W)) u_mem (
    .clk(clk), .wr_en(ld_ok), .wr_col(ld_col), .wr_chunk(ld_chunk),
    .wr_data(ld_data), .rd_chunk(chunk_q), .rd_slices(slices));

  bmv_accum #(.NCOLS(NCOLS), .CHUNK_W(CHUNK_W), .MAX_CNT(VEC_BITS)) u_acc (
    .clk(clk), .rst_n(rst_n), .fire(fire), .first(first_chunk),
    .chunk(in_data), .slices(slices), .acc_flat(acc_flat));

  bmv_scan #(.NCOLS(NCOLS), .CNT_W(CNT_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(vec_done), .acc_flat(acc_flat),
    .busy(scan_busy), .done(scan_done), .best_val(res_max), .best_idx(res_idx));

  assign res_valid     = (phase_q == PH_EMIT);
  assign res_frame_err = err_q;

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_after_scan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(scan_busy));

  p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy |-> !in_ready);

  p_max_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_max <= CNT_W'(VEC_BITS)));

  p_no_load_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_busy || res_valid) |-> !ld_ok);
endmodule

// File: tb/bmv_argmax_top_tb_top.sv
module bmv_argmax_top_tb_top;
  localparam int VEC_BITS = 1000;
  localparam int CHUNK_W  = 100;
  localparam int NCOLS    = 16;
  localparam int NCHUNK   = VEC_BITS / CHUNK_W;
  localparam int CNT_W    = $clog2(VEC_BITS + 1);
  localparam int IDX_W    = $clog2(NCOLS);
  localparam int CHK_W    = $clog2(NCHUNK);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [IDX_W-1:0] ld_col = '0;
  logic [CHK_W-1:0] ld_chunk = '0;
  logic [CHUNK_W-1:0] ld_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [CHUNK_W-1:0] in_data = '0;
  logic in_last = 1'b0;
  logic res_valid;
  logic [CNT_W-1:0] res_max;
  logic [IDX_W-1:0] res_idx;
  logic res_frame_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [VEC_BITS-1:0] colv [NCOLS];

  always #10 clk = ~clk;  // 50 MHz

  bmv_argmax_top #(.VEC_BITS(VEC_BITS), .CHUNK_W(CHUNK_W), .NCOLS(NCOLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_col(ld_col),
    .ld_chunk(ld_chunk), .ld_data(ld_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .res_valid(res_valid), .res_max(res_max), .res_idx(res_idx),
    .res_frame_err(res_frame_err));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [VEC_BITS-1:0] rand_vec(input int pct);
    logic [VEC_BITS-1:0] v;
    for (int i = 0; i < VEC_BITS; i++) v[i] = (($urandom % 100) < pct);
    return v;
  endfunction

  // Independent model: scores, then the first column with the top score
  task automatic model(input logic [VEC_BITS-1:0] v, output int mx, output int ix);
    mx = -1; ix = 0;
    for (int c = 0; c < NCOLS; c++) begin
      int s;
      s = $countones(v & colv[c]);
      if (s > mx) begin mx = s; ix = c; end
    end
  endtask

  task automatic write_slice(input int col, input int chk, input logic [CHUNK_W-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_col = IDX_W'(col); ld_chunk = CHK_W'(chk); ld_data = d;
    @(posedge clk);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_col(input int col, input logic [VEC_BITS-1:0] v);
    for (int k = 0; k < NCHUNK; k++) write_slice(col, k, v[k*CHUNK_W +: CHUNK_W]);
    colv[col] = v;
  endtask

  // bad_last: 0 proper, 1 extra last on chunk 3, 2 last never set
  // poke: 1 -> try writes mid-vector and during the scan (must be ignored)
  task automatic run_vec(input logic [VEC_BITS-1:0] v, input int bad_last,
                         input bit poke, input string tag);
    int mx, ix, lat;
    model(v, mx, ix);
    for (int k = 0; k < NCHUNK; k++) begin
      if (poke && k == 5) begin
        @(negedge clk);
        in_valid = 1'b0;
        ld_en = 1'b1; ld_col = IDX_W'(2); ld_chunk = CHK_W'(5); ld_data = '1;
        @(posedge clk);
      end
      @(negedge clk);
      ld_en = 1'b0;
      in_valid = 1'b1;
      in_data = v[k*CHUNK_W +: CHUNK_W];
      in_last = (bad_last == 2) ? 1'b0 : ((k == NCHUNK - 1) || (bad_last == 1 && k == 3));
      if (!in_ready) check(0, "R5 ready during vector", 0, 1);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    if (poke) begin
      ld_en = 1'b1; ld_col = IDX_W'(2); ld_chunk = CHK_W'(0); ld_data = '1;
    end
    lat = 0;
    while (!res_valid && lat < NCOLS + 20) begin
      check(!in_ready, {"R5 ready low ", tag}, int'(in_ready), 0);
      @(posedge clk);
      lat++;
      @(negedge clk);
      ld_en = 1'b0;
    end
    check(lat == NCOLS, {"R6 latency ", tag}, lat, NCOLS);
    check(!in_ready, {"R5 ready low in result cycle ", tag}, int'(in_ready), 0);
    check(int'(res_max) == mx, {"R1 max ", tag}, int'(res_max), mx);
    check(int'(res_idx) == ix, {"R4 argmax ", tag}, int'(res_idx), ix);
    check(res_frame_err == (bad_last != 0), {"R9 frame flag ", tag},
          int'(res_frame_err), int'(bad_last != 0));
    @(posedge clk);
    @(negedge clk);
    check(in_ready && !res_valid, {"R5 R6 ready back ", tag},
          int'({in_ready, res_valid}), 2);
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1, "R5 reset ready", int'(in_ready), 1);
    check(res_valid == 1'b0, "R6 reset no result", int'(res_valid), 0);
  endtask

  task automatic t_random();
    for (int c = 0; c < NCOLS; c++) load_col(c, rand_vec(50));
    for (int n = 0; n < 3; n++) run_vec(rand_vec(30 + 20 * n), 0, 0, "R1 R2 random");
    // back-to-back: second vector sparse, a leak would inflate it (R7)
    run_vec(rand_vec(90), 0, 0, "R7 dense");
    run_vec(rand_vec(3), 0, 0, "R7 sparse");
  endtask

  task automatic t_extremes();
    load_col(7, '1);
    run_vec('1, 0, 0, "R3 all ones");
    check(int'(res_max) == VEC_BITS, "R3 full score", int'(res_max), VEC_BITS);
    run_vec('0, 0, 0, "R3 all zero");
    check(res_max == '0 && res_idx == '0, "R3 zero result", int'(res_max), 0);
  endtask

  task automatic t_ties();
    logic [VEC_BITS-1:0] w;
    w = rand_vec(40);
    for (int c = 0; c < NCOLS; c++) load_col(c, w);
    run_vec(rand_vec(60), 0, 0, "R4 all equal");
    check(res_idx == '0, "R4 all equal lowest", int'(res_idx), 0);
    for (int c = 0; c < NCOLS; c++) load_col(c, '0);
    load_col(5, w); load_col(11, w);
    run_vec('1, 0, 0, "R4 pair tie");
    check(int'(res_idx) == 5, "R4 pair lowest", int'(res_idx), 5);
  endtask

  task automatic t_loads();
    for (int c = 0; c < NCOLS; c++) load_col(c, rand_vec(10));
    run_vec('1, 0, 1, "R8 pokes ignored");
    // out-of-range slice: would alias into column 2 if taken
    write_slice(1, NCHUNK, '1);
    run_vec('1, 0, 0, "R8 after ignored writes");
    write_slice(4, 3, '1);
    colv[4][3*CHUNK_W +: CHUNK_W] = '1;
    run_vec('1, 0, 0, "R8 accepted write");
    check(int'(res_idx) == 4, "R8 written column wins", int'(res_idx), 4);
  endtask

  task automatic t_frame();
    for (int c = 0; c < NCOLS; c++) load_col(c, rand_vec(50));
    run_vec(rand_vec(50), 1, 0, "R9 early last");
    run_vec(rand_vec(50), 2, 0, "R9 missing last");
    run_vec(rand_vec(50), 0, 0, "R9 clean after error");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_random();
    t_extremes();
    t_ties();
    t_loads();
    t_frame();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end
endmodule